// File: doc/BRIEF.md
# Conversion-time tracking speed controller

This block closes a digital loop around an asynchronous successive-approximation converter. At each sampling edge it checks whether the previous conversion finished in time. It then steps a 5-level thermometer setting that tells the analog side how hard to boost its comparator and switch drivers. A late conversion raises the setting and an early one lowers it, so the boost stays only as strong as the current process, voltage and temperature need. The loop settles into a dither between two adjacent levels, and the block raises a lock flag when it sees that dither.

The end-of-conversion signal comes from the converter's last bit decision. It is resynchronised into the reference clock domain and held back by a guard delay before it is compared with the sampling edge. The guard must exceed the change in conversion time that one level step causes, so that the dither at lock never loses a bit. A divide-by-two phase picks the measured periods and a divide-by-four phase picks the update points. A binary copy of the level is provided for observation.

The lock tracker is a five-state machine that remembers the previous update:
- `HIST_EMPTY`: no update since reset or wake.
- `HIST_UP_MOVED`: the last update raised the level.
- `HIST_UP_PINNED`: the last update asked for a raise at the top and did not move.
- `HIST_DN_MOVED`: the last update lowered the level.
- `HIST_DN_PINNED`: the last update asked for a lower at the bottom and did not move.

Every update moves the machine to the state that matches its own direction and its moved/pinned outcome, whatever the current state. A wake pulse returns it to `HIST_EMPTY`.

Top module: `convtime_tracker`

## Requirements
- R1: While `rst_n` is low, and in the clock after a cycle with `wake` high, `therm` is 1111, `bin` is 4, `slow_flag` is 0 and `locked` is 0. The sampling-edge count restarts, so the next update falls on the fourth sampling rising edge after wake.
- R2: `eoc` passes a two-flop synchroniser and a `GUARD_CYC`-cycle delay. Delayed rises in the first `GUARD_CYC`+2 clocks after a sampling rise are ignored. If `eoc` is first sampled k clock edges after the edge that samples the sampling rise, and there are P clocks between sampling rises, the conversion counts as early when k + `GUARD_CYC` + 3 <= P. Otherwise it counts as late. This includes the case where the delayed rise lands on the same clock as the next sampling rise.
- R3: `slow_flag` holds the decision: 1 means late (accelerate) and 0 means early (decelerate). It is refreshed at the 2nd, 4th, 6th and later sampling rising edges after wake, from the period that just ended.
- R4: `therm` changes only at the 4th, 8th, 12th and later sampling rising edges after wake. Between those edges it holds.
- R5: `therm` is a thermometer code filled from bit 0. At an update a late decision adds one set bit (one level up) and an early decision clears the top set bit (one level down).
- R6: An increase at 1111 and a decrease at 0000 leave `therm` unchanged.
- R7: `bin` equals the number of set bits in `therm` (0 to 4).
- R8: Starting from 1111 with every conversion early, `therm` reaches 0000 at the fourth update.
- R9: `locked` rises at an update that moves the level in the opposite direction to the previous update, when the previous update also moved the level.
- R10: `locked` falls at an update whose direction matches the previous update's, counting pinned updates. Otherwise it holds, and it never changes between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 1 | Synchronous restart of the loop |
| samp | input | 1 | Sampling clock, sampled by `clk` |
| eoc | input | 1 | End-of-conversion, asynchronous |
| therm | output | TW | Thermometer acceleration level |
| bin | output | clog2(TW+1) | Binary count of the level |
| slow_flag | output | 1 | Latest early/late decision, 1 = late |
| locked | output | 1 | Dither between adjacent levels detected |

## Verification
The collision of interest is a delayed end-of-conversion rise that lands on the same clock as the next sampling rise. That clock both clears the period's record and would set it. The bench provokes it by asserting `eoc` exactly `P - GUARD_CYC - 2` clocks after the sampling rise and expects a late decision, so `therm` stays at 1111. It runs the same stimulus one clock earlier and expects an early decision that walks the level to 0000. Conversions that overrun into the next period hit the blanking window at the start of that period, and the dither rows show that such spills are not counted as early.

// File: rtl/convtrk_pkg.sv
package convtrk_pkg;

    typedef enum logic [2:0] {
        HIST_EMPTY,
        HIST_UP_MOVED,
        HIST_UP_PINNED,
        HIST_DN_MOVED,
        HIST_DN_PINNED
    } hist_e;

endpackage

// File: rtl/convtrk_guard.sv
module convtrk_guard #(
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc,
    output logic deoc_rise
);

    logic [1:0]           sync_q;
    logic [GUARD_CYC-1:0] dly_q;
    logic                 last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            dly_q  <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q   <= {sync_q[0], eoc};
            dly_q[0] <= sync_q[1];
            for (int i = 1; i < GUARD_CYC; i++) begin
                dly_q[i] <= dly_q[i-1];
            end
            last_q <= dly_q[GUARD_CYC-1];
        end
    end

    assign deoc_rise = dly_q[GUARD_CYC-1] & ~last_q;

endmodule

// File: rtl/convtrk_phase.sv
module convtrk_phase #(
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic samp,
    input  logic deoc_rise,
    output logic det_stb,
    output logic upd_stb,
    output logic slow
);

    localparam int BLANK = GUARD_CYC + 2;
    localparam int CW    = $clog2(BLANK + 1);

    logic          samp_q;
    logic          div2_q;
    logic          div4_q;
    logic          seen_q;
    logic [CW-1:0] blank_q;
    logic          samp_rise;

    assign samp_rise = samp & ~samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q  <= 1'b0;
            div2_q  <= 1'b0;
            div4_q  <= 1'b0;
            seen_q  <= 1'b0;
            blank_q <= '0;
        end else begin
            samp_q <= samp;
            if (wake) begin
                div2_q  <= 1'b0;
                div4_q  <= 1'b0;
                seen_q  <= 1'b0;
                blank_q <= '0;
            end else if (samp_rise) begin
                div2_q  <= ~div2_q;
                if (div2_q) div4_q <= ~div4_q;
                seen_q  <= 1'b0;
                blank_q <= CW'(BLANK);
            end else begin
                if (blank_q != '0) blank_q <= blank_q - 1'b1;
                if (deoc_rise && blank_q == '0) seen_q <= 1'b1;
            end
        end
    end

    assign det_stb = samp_rise & div2_q & ~wake;
    assign upd_stb = det_stb & div4_q;
    assign slow    = ~seen_q;

    assert_record_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_rise && !wake) |=> !seen_q);

endmodule

// File: rtl/convtrk_lock.sv
module convtrk_lock
    import convtrk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic upd_stb,
    input  logic step_up,
    input  logic moved,
    output logic locked
);

    hist_e state_q, state_d;
    logic  prev_up, prev_dn, prev_moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HIST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wake) begin
            state_d = HIST_EMPTY;
        end else if (upd_stb) begin
            if (step_up) state_d = moved ? HIST_UP_MOVED : HIST_UP_PINNED;
            else         state_d = moved ? HIST_DN_MOVED : HIST_DN_PINNED;
        end
    end

    always_comb begin
        prev_up    = 1'b0;
        prev_dn    = 1'b0;
        prev_moved = 1'b0;
        unique case (state_q)
            HIST_EMPTY:     ;
            HIST_UP_MOVED:  begin prev_up = 1'b1; prev_moved = 1'b1; end
            HIST_UP_PINNED: prev_up = 1'b1;
            HIST_DN_MOVED:  begin prev_dn = 1'b1; prev_moved = 1'b1; end
            HIST_DN_PINNED: prev_dn = 1'b1;
            default:        ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (wake) begin
            locked <= 1'b0;
        end else if (upd_stb) begin
            if ((prev_up && step_up) || (prev_dn && !step_up)) locked <= 1'b0;
            else if (prev_moved && moved)                      locked <= 1'b1;
        end
    end

    assert_lock_only_at_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_stb && !wake) |=> $stable(locked));

    assert_lock_needs_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (state_q == HIST_UP_MOVED || state_q == HIST_DN_MOVED));

endmodule

// File: rtl/convtime_tracker.sv
module convtime_tracker #(
    parameter int  TW        = 4,
    parameter int  GUARD_CYC = 4,
    localparam int BW        = $clog2(TW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wake,
    input  logic          samp,
    input  logic          eoc,
    output logic [TW-1:0] therm,
    output logic [BW-1:0] bin,
    output logic          slow_flag,
    output logic          locked
);

    logic          deoc_rise;
    logic          det_stb;
    logic          upd_stb;
    logic          slow;
    logic [TW-1:0] therm_nx;
    logic          moved;

    convtrk_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc       (eoc),
        .deoc_rise (deoc_rise)
    );

    convtrk_phase #(.GUARD_CYC(GUARD_CYC)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake      (wake),
        .samp      (samp),
        .deoc_rise (deoc_rise),
        .det_stb   (det_stb),
        .upd_stb   (upd_stb),
        .slow      (slow)
    );

    convtrk_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake    (wake),
        .upd_stb (upd_stb),
        .step_up (slow),
        .moved   (moved),
        .locked  (locked)
    );

    assign therm_nx = slow ? {therm[TW-2:0], 1'b1} : {1'b0, therm[TW-1:1]};
    assign moved    = (therm_nx != therm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            therm     <= '1;
            slow_flag <= 1'b0;
        end else if (wake) begin
            therm     <= '1;
            slow_flag <= 1'b0;
        end else begin
            if (upd_stb) therm     <= therm_nx;
            if (det_stb) slow_flag <= slow;
        end
    end

    always_comb begin
        bin = '0;
        for (int i = 0; i < TW; i++) begin
            bin = bin + BW'(therm[i]);
        end
    end

    assert_wake_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (therm == '1 && !locked && !slow_flag));

    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_stb && !wake) |=> $stable(therm));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |=> ($countones(therm ^ $past(therm)) <= 1));

    assert_therm_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm & (therm + 1'b1)) == '0));

    assert_top_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && slow && therm == '1) |=> (therm == '1));

endmodule

// File: tb/convtime_tracker_bench.sv
module convtime_tracker_bench;

    localparam int G  = 4;
    localparam int P  = 40;
    localparam int NR = 8;

    localparam int T_BASE [NR] = '{20, 37, 45, 44, 33, 34, 36, 20};
    localparam int T_SLOPE[NR] = '{ 0,  0,  4,  3,  0,  0,  3,  0};
    localparam int T_NUPD [NR] = '{ 6,  3,  8,  7,  5,  3,  7,  3};
    localparam int T_WAKE [NR] = '{ 1,  1,  1,  1,  1,  1,  1,  0};
    localparam int T_LVL  [NR] = '{ 0,  4,  2,  3,  0,  4,  1,  0};
    localparam int T_LOCK [NR] = '{ 0,  0,  1,  1,  0,  0,  1,  0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 1'b0;
    logic       samp = 1'b0;
    logic       eoc = 1'b0;
    logic [3:0] therm;
    logic [2:0] bin;
    logic       slow_flag;
    logic       locked;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    int  lvl, base, slope;
    bit  hv, hdir, hmoved, elock;

    convtime_tracker #(.TW(4), .GUARD_CYC(G)) u_convtime_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake      (wake),
        .samp      (samp),
        .eoc       (eoc),
        .therm     (therm),
        .bin       (bin),
        .slow_flag (slow_flag),
        .locked    (locked)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int dly_of(input int l);
        return base - slope * l;
    endfunction

    function automatic bit late_of(input int l);
        return (dly_of(l) + G + 3) > P;
    endfunction

    function automatic int therm_of(input int l);
        return (1 << l) - 1;
    endfunction

    task automatic run_period(input int d);
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            samp = (c < P / 2);
            eoc  = (c >= d) && (c < d + 2);
        end
    endtask

    task automatic do_wake();
        repeat (10) @(negedge clk);
        wake = 1'b1;
        samp = 1'b0;
        eoc  = 1'b0;
        @(negedge clk);
        wake = 1'b0;
        chk(therm == 4'hF, "R1 therm after wake", therm, 15);
        chk(bin == 3'd4, "R1 bin after wake", bin, 4);
        chk(!locked, "R1 locked after wake", locked, 0);
        chk(!slow_flag, "R1 slow_flag after wake", slow_flag, 0);
        lvl   = 4;
        hv    = 1'b0;
        elock = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        lvl = 4; hv = 1'b0; hdir = 1'b0; hmoved = 1'b0; elock = 1'b0;
        base = 0; slope = 0;
        repeat (3) @(negedge clk);
        chk(therm == 4'hF, "R1 therm in reset", therm, 15);
        chk(bin == 3'd4, "R1 bin in reset", bin, 4);
        chk(!locked && !slow_flag, "R1 flags in reset", {locked, slow_flag}, 0);
        rst_n = 1'b1;

        for (int r = 0; r < NR; r++) begin
            base  = T_BASE[r];
            slope = T_SLOPE[r];
            if (T_WAKE[r] != 0) do_wake();
            for (int u = 1; u <= T_NUPD[r]; u++) begin
                bit lt, mv;
                int nl;
                run_period(dly_of(lvl));
                run_period(dly_of(lvl));
                // R4: the detection edge between updates must not move the code
                chk(therm == 4'(therm_of(lvl)), "R4 hold between updates", therm, therm_of(lvl));
                chk(slow_flag == late_of(lvl), "R3 mid decision", slow_flag, late_of(lvl));
                run_period(dly_of(lvl));
                lt = late_of(lvl);
                nl = lt ? ((lvl < 4) ? lvl + 1 : 4) : ((lvl > 0) ? lvl - 1 : 0);
                mv = (nl != lvl);
                if (hv && hdir == lt)          elock = 1'b0;
                else if (hv && hmoved && mv)   elock = 1'b1;
                hv = 1'b1; hdir = lt; hmoved = mv;
                lvl = nl;
                run_period(dly_of(lvl));
                if (mv) chk(therm == 4'(therm_of(lvl)), "R5 step", therm, therm_of(lvl));
                else    chk(therm == 4'(therm_of(lvl)), "R6 saturate", therm, therm_of(lvl));
                chk(bin == 3'(lvl), "R7 binary level", bin, lvl);
                chk(slow_flag == lt, "R3 update decision", slow_flag, lt);
                if (elock) chk(locked == elock, "R9 lock set", locked, elock);
                else       chk(locked == elock, "R10 lock clear", locked, elock);
                if (r == 0 && u == 4) begin
                    // R8: bottom reached within four updates from the top
                    chk(therm == 4'h0, "R8 reach bottom", therm, 0);
                end
            end
            // R2: rows 4 and 5 sit on either side of the early/late threshold
            chk(bin == 3'(T_LVL[r]), "R2 row final level", bin, T_LVL[r]);
            chk(locked == (T_LOCK[r] != 0), "R9 row final lock", locked, T_LOCK[r]);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule